// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block answers on a two-wire serial bus (I2C) as if it were a small byte-wide EEPROM. Its 256 bytes are held in on-chip registers. A system clock samples SCL and SDA through two-flop synchronizers. This clock must run at least eight times faster than SCL. The block pulls SDA low through an open-drain output to acknowledge bytes and to return read data.

A controller addresses the block with an 8-bit byte. The top nibble of that byte is 1010, the next three bits come from the `sel_i` pins, and the last bit selects read (1) or write (0). After a write address, the first byte sets the address pointer. Any further bytes are data. They are held in a one-page buffer and reach the array only when STOP arrives. After each committed write, the block ignores its own address for a programmed number of clock cycles, to stand for the programming time of a real part.

Reads start at the pointer and advance it one byte at a time. A random read first sets the pointer with an address-only write, then issues a read.

Top module: `eeprom_i2c_target`

## Requirements
- R1: An address byte whose upper seven bits equal {1010, sel_i} is acknowledged (SDA pulled low in the ninth clock). Any other address gets no acknowledge, and the block leaves SDA alone until the next START.
- R2: A write of address byte plus one data byte, ended by STOP, stores that byte at that address. A later read returns it.
- R3: Data bytes after the address are stored at successive addresses. The low log2(PAGE_BYTES) address bits wrap within the page (default 16 bytes), and the upper bits stay fixed. Bytes in other pages are not touched.
- R4: A read with no address phase returns the byte at the pointer. Each byte returned advances the pointer by one, and the pointer keeps its value between transfers.
- R5: An address-only write ended by STOP loads the pointer, changes no memory and starts no busy window.
- R6: After a STOP that commits data, the block does not acknowledge its address for BUSY_CYCLES system clocks. After that window it acknowledges again.
- R7: Sequential reads move the pointer from FFh to 00h.
- R8: Buffered write data is dropped when a repeated START comes before STOP. Nothing is stored and no busy window starts.
- R9: When the controller answers a read byte with no acknowledge, the block releases SDA and keeps it released until the next START.
- R10: After reset, SDA is released, the pointer is 00h and every memory byte reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sel_i | input | 3 | Address select bits, placed in address bits 3..1 |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |

## Verification
A corrupted pointer shows up on the first data byte of the next current-address read. A wrong page wrap or a lost buffer entry shows up only when the affected bytes are read back, which can be several transfers later. A busy counter that is stuck or too short changes the acknowledge of the very next address byte after STOP. A receive or transmit state that is off by one moves the acknowledge or the data bits by one SCL period, so the first byte sampled shows it.

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target #(
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] sel_i,
  output logic       sda_pull_o
);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_ADEV, S_ADDR, S_AADDR, S_DATA, S_ADATA, S_RD, S_RACK
  } state_t;

  state_t          st;
  logic [2:0]      scl_q, sda_q;
  logic [3:0]      cnt;
  logic [7:0]      sr, tx, ptr;
  logic [7-PW:0]   base_hi;
  logic            rw_q, mack;
  logic [BW-1:0]   busy_cnt;
  logic [PAGE_BYTES-1:0] vmask;
  logic [7:0]      wbuf [PAGE_BYTES];
  logic [7:0]      mem  [256];

  wire scl   = scl_q[1];
  wire sda   = sda_q[1];
  wire rise  = scl & ~scl_q[2];
  wire fall  = ~scl & scl_q[2];
  wire start_c = scl & scl_q[2] & sda_q[2] & ~sda;
  wire stop_c  = scl & scl_q[2] & ~sda_q[2] & sda;
  wire busy  = busy_cnt != '0;
  wire match = sr[7:1] == {4'b1010, sel_i};
  wire byte_in = fall && cnt == 4'd8;
  wire dev_ack = st == S_ADEV;
  wire rd_done = st == S_RD && fall && cnt == 4'd8 && !start_c && !stop_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; scl_q <= '1; sda_q <= '1; cnt <= '0; sr <= '0; tx <= '0;
      ptr <= '0; base_hi <= '0; rw_q <= 1'b0; mack <= 1'b0; busy_cnt <= '0;
      vmask <= '0; sda_pull_o <= 1'b0;
      for (int i = 0; i < PAGE_BYTES; i++) wbuf[i] <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (start_c) begin
        st <= S_DEV; cnt <= '0; sda_pull_o <= 1'b0; vmask <= '0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_pull_o <= 1'b0;
        if (|vmask) begin
          for (int i = 0; i < PAGE_BYTES; i++)
            if (vmask[i]) mem[{base_hi, PW'(i)}] <= wbuf[i];
          busy_cnt <= BW'(BUSY_CYCLES);
          vmask <= '0;
        end
      end else begin
        unique case (st)
          S_DEV, S_ADDR, S_DATA: begin
            if (rise) begin
              sr <= {sr[6:0], sda}; cnt <= cnt + 1'b1;
            end else if (byte_in) begin
              if (st == S_DEV) begin
                if (match && !busy) begin
                  sda_pull_o <= 1'b1; rw_q <= sr[0]; st <= S_ADEV;
                end else st <= S_IDLE;
              end else if (st == S_ADDR) begin
                sda_pull_o <= 1'b1; ptr <= sr; base_hi <= sr[7:PW]; st <= S_AADDR;
              end else begin
                sda_pull_o <= 1'b1;
                wbuf[ptr[PW-1:0]]  <= sr;
                vmask[ptr[PW-1:0]] <= 1'b1;
                ptr <= {ptr[7:PW], ptr[PW-1:0] + PW'(1)};
                st <= S_ADATA;
              end
            end
          end
          S_ADEV, S_AADDR, S_ADATA: begin
            if (fall) begin
              cnt <= '0;
              if (st == S_ADEV && rw_q) begin
                tx <= mem[ptr]; sda_pull_o <= ~mem[ptr][7]; st <= S_RD;
              end else begin
                sda_pull_o <= 1'b0;
                st <= (st == S_ADEV) ? S_ADDR : S_DATA;
              end
            end
          end
          S_RD: begin
            if (rise) cnt <= cnt + 1'b1;
            else if (fall) begin
              if (cnt == 4'd8) begin
                sda_pull_o <= 1'b0; ptr <= ptr + 8'd1; st <= S_RACK;
              end else begin
                sda_pull_o <= ~tx[6]; tx <= {tx[6:0], 1'b0};
              end
            end
          end
          S_RACK: begin
            if (rise) mack <= ~sda;
            else if (fall) begin
              if (mack) begin
                tx <= mem[ptr]; sda_pull_o <= ~mem[ptr][7]; cnt <= '0; st <= S_RD;
              end else st <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module eeprom_i2c_target_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl,
  input logic       pull,
  input logic       busy,
  input logic       dev_ack,
  input logic       rd_done,
  input logic [7:0] ptr
);
  // R1
  pull_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull) |-> !scl);
  // R6
  busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> !busy);
  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> ptr == $past(ptr) + 8'd1);
  // R10
  reset_release_chk: assert property (@(posedge clk)
    !rst_n |=> !pull);
endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl(scl_i), .pull(sda_pull_o),
  .busy(busy), .dev_ack(dev_ack), .rd_done(rd_done), .ptr(ptr)
);

// File: tb/test_eeprom_i2c_target.sv
module test_eeprom_i2c_target;
  localparam int BUSY = 500;
  localparam int PAGE = 16;
  localparam int T = 100;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] sel = 3'b101;
  logic sda_pull;
  wire  sda_line = sda_m & ~sda_pull;

  eeprom_i2c_target #(.PAGE_BYTES(PAGE), .BUSY_CYCLES(BUSY)) i_eeprom_i2c_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sel_i(sel), .sda_pull_o(sda_pull));

  always #10 clk = ~clk;

  int errs = 0, checks = 0;
  bit done = 1'b0;
  int exp_q[$]; int obs_q[$]; string req_q[$];

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (obs_q.size() > 0 && exp_q.size() > 0) begin
      int a, e; string r;
      a = obs_q.pop_front(); e = exp_q.pop_front(); r = req_q.pop_front();
      chk(r, a, e);
    end
  end

  task automatic expect_v(int v, string r);
    exp_q.push_back(v); req_q.push_back(r);
  endtask

  task automatic start_c();
    sda_m = 1; #T; scl_m = 1; #T; sda_m = 0; #T; scl_m = 0; #T;
  endtask
  task automatic stop_c();
    sda_m = 0; #T; scl_m = 1; #T; sda_m = 1; #T;
  endtask
  task automatic wbyte(input logic [7:0] b);
    logic a;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #T; scl_m = 1; #(2*T); scl_m = 0; #T;
    end
    sda_m = 1; #T; scl_m = 1; #T; a = ~sda_line; #T; scl_m = 0; #T;
    obs_q.push_back(int'(a));
  endtask
  task automatic rbyte(input bit give_ack);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1; #T; scl_m = 1; #T; v[i] = sda_line; #T; scl_m = 0; #T;
    end
    obs_q.push_back(int'(v));
    sda_m = ~give_ack; #T; scl_m = 1; #(2*T); scl_m = 0; #T;
  endtask

  task automatic dev(bit rw, int ack, string r);
    wbyte({4'b1010, sel, rw}); expect_v(ack, r);
  endtask
  task automatic set_ptr(logic [7:0] a, string r);
    start_c(); dev(0, 1, r); wbyte(a); expect_v(1, r);
  endtask
  task automatic rd(int exp, bit last, string r);
    rbyte(!last); expect_v(exp, r);
  endtask
  task automatic wait_busy();
    #(BUSY*20 + 2000);
  endtask
  task automatic wr1(logic [7:0] a, logic [7:0] d, string r);
    set_ptr(a, r); wbyte(d); expect_v(1, r); stop_c(); wait_busy();
  endtask

  initial begin
    #5; #200; rst_n = 1; #400;
    // R10 reset state
    chk("R10", int'(sda_pull), 0);
    set_ptr(8'h20, "R10"); start_c(); dev(1, 1, "R10"); rd(0, 1, "R10"); stop_c();
    // R1 wrong select bits
    start_c(); wbyte({4'b1010, 3'b011, 1'b0}); expect_v(0, "R1"); stop_c();
    start_c(); wbyte(8'hB0 | {4'b0, sel, 1'b0}); expect_v(0, "R1"); stop_c();
    // R2 single write, R6 busy
    set_ptr(8'h05, "R2"); wbyte(8'hA5); expect_v(1, "R2"); stop_c();
    start_c(); dev(0, 0, "R6"); stop_c();
    wait_busy();
    set_ptr(8'h05, "R6"); start_c(); dev(1, 1, "R6"); rd(8'hA5, 1, "R2"); stop_c();
    // R3 page write with wrap from 1Eh
    set_ptr(8'h1E, "R3");
    wbyte(8'h11); expect_v(1, "R3"); wbyte(8'h22); expect_v(1, "R3");
    wbyte(8'h33); expect_v(1, "R3"); wbyte(8'h44); expect_v(1, "R3");
    stop_c(); wait_busy();
    set_ptr(8'h10, "R3"); start_c(); dev(1, 1, "R3");
    rd(8'h33, 0, "R3"); rd(8'h44, 1, "R3"); stop_c();
    set_ptr(8'h1E, "R3"); start_c(); dev(1, 1, "R3"); rd(8'h11, 1, "R3"); stop_c();
    // R4 current-address read continues at 1Fh, then 20h untouched
    start_c(); dev(1, 1, "R4"); rd(8'h22, 1, "R4"); stop_c();
    start_c(); dev(1, 1, "R4"); rd(8'h00, 1, "R3"); stop_c();
    // R5 address-only write, no busy
    set_ptr(8'h05, "R5"); stop_c();
    start_c(); dev(1, 1, "R5"); rd(8'hA5, 1, "R5"); stop_c();
    // R7 pointer wrap
    wr1(8'hFF, 8'h77, "R7"); wr1(8'h00, 8'h88, "R7");
    set_ptr(8'hFF, "R7"); start_c(); dev(1, 1, "R7");
    rd(8'h77, 0, "R7"); rd(8'h88, 1, "R7"); stop_c();
    // R8 repeated START drops data
    set_ptr(8'h40, "R8"); wbyte(8'h99); expect_v(1, "R8");
    start_c(); dev(1, 1, "R8"); rd(8'h00, 1, "R8");
    // R9 released after controller NACK, across a clock pulse
    #T; chk("R9", int'(sda_pull), 0);
    scl_m = 1; #T; chk("R9", int'(sda_pull), 0);
    scl_m = 0; #T; chk("R9", int'(sda_pull), 0);
    stop_c();
    set_ptr(8'h40, "R8"); start_c(); dev(1, 1, "R8"); rd(8'h00, 1, "R8"); stop_c();
    #1000;
    chk("queue", exp_q.size(), obs_q.size());
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule